// File: doc/BRIEF.md
# Dual-Issue Instruction Queue Dispatcher

This block sits between instruction fetch and the execution units of an in-order superscalar core. Fetch hands it up to four decoded instructions per cycle. Each instruction carries a three-bit unit-class code and an opaque payload. The block holds them in a shifting queue, oldest at slot 0. Every cycle it decides which of the oldest instructions can leave.

Only the two oldest slots may issue to execution units. There are two integer units, a floating-point unit and a load/store unit. Each unit has a single-entry reservation station and reports whether that station is free. A separate branch port may also take a branch from the third-oldest slot in a cycle where both older slots issue, so up to three instructions can leave in one cycle. Issue is strictly in program order. A flush input empties the queue at once.

The unit-class codes are:

| Code | Class |
|------|-------|
| 0 | simple integer |
| 1 | complex integer (multiply or divide) |
| 2 | floating point |
| 3 | load/store |
| 4 | branch |

The unit bit order, used for both `unit_free` and `issue_valid`, is:

| Bit | Unit |
|-----|------|
| 0 | integer unit 1 |
| 1 | integer unit 2 |
| 2 | floating-point unit |
| 3 | load/store unit |
| 4 | branch port |

Top module: `iq_dual_dispatch`

## Requirements
- R1: After reset the queue is empty, `issue_valid` is all zero and `fetch_ready` is high.
- R2: `fetch_ready` is high exactly when `flush` is low and occupancy is at most DEPTH-4. When `fetch_valid` and `fetch_ready` are both high, the first `fetch_count` lanes (capped at 4) are appended to the queue, lane 0 (bits [2:0] of `fetch_cls`, bits [DW-1:0] of `fetch_data`) being the oldest.
- R3: Only slots 0 and 1 may issue to the four execution units (bits 0 to 3). At most two execution-unit bits of `issue_valid` are high in any cycle, and no unit receives two instructions.
- R4: Issue is in order: slot 1 issues only when slot 0 issues in the same cycle, and slot 2 issues only when slots 0 and 1 both do.
- R5: A simple-integer instruction goes to integer unit 1 when that unit is free and not already taken, otherwise to integer unit 2. A complex-integer instruction goes only to integer unit 1.
- R6: Floating-point, load/store and branch instructions go only to their own unit, and only when its `unit_free` bit is high.
- R7: A branch in slot 2 is issued on the branch port when slots 0 and 1 both issue, the branch port is free, and no older branch issued in that cycle.
- R8: While `flush` is high nothing issues and the fetch lanes are discarded. On the next cycle the queue is empty.
- R9: Issued entries leave the queue and younger entries move down with their order kept. Each issued payload appears on the `issue_data` lane of the unit it went to, the lane for unit u being bits [u*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties the queue and blocks issue this cycle |
| fetch_valid | input | 1 | Fetch group offered |
| fetch_count | input | 3 | Number of valid lanes in the group (0 to 4) |
| fetch_cls | input | 12 | Class codes, 3 bits per lane |
| fetch_data | input | 4*DW | Payloads, DW bits per lane |
| fetch_ready | output | 1 | Room for a full group of four |
| unit_free | input | 5 | Free flags of the reservation stations, in unit bit order |
| issue_valid | output | 5 | Instruction handed to each unit this cycle |
| issue_data | output | 5*DW | Payload for each unit |

## Verification
The hardest case to reach is a full three-wide issue. It needs two execution-class instructions in slots 0 and 1 that do not collide on a unit, a branch directly behind them, and the right units free, all in the same cycle. A directed sequence builds exactly that group while every unit is held busy, and then frees all units at once. Random traffic that mixes classes and free flags then reaches the other steering combinations, checked against a bench model of the queue.

// File: rtl/iq_pkg.sv
// Package: shared class codes and unit indices for the dispatch queue.
// Assumes: class codes 5..7 are never produced by decode.
package iq_pkg;

    typedef enum logic [2:0] {
        CLS_SIMPLE = 3'd0,
        CLS_CPLX   = 3'd1,
        CLS_FP     = 3'd2,
        CLS_LS     = 3'd3,
        CLS_BR     = 3'd4
    } iclass_e;

    localparam int CLS_W   = 3;
    localparam int LANES   = 4;   // fetch group width
    localparam int LOOK    = 3;   // slots examined by the steering logic
    localparam int UNITS   = 5;
    localparam int U_INT1  = 0;
    localparam int U_INT2  = 1;
    localparam int U_FPU   = 2;
    localparam int U_LSU   = 3;
    localparam int U_BR    = 4;

endpackage

// File: rtl/iq_store.sv
// Module: iq_store
// Shifting instruction queue. Each cycle it drops n_pop entries from the
// head and appends up to four fetch lanes behind the survivors.
// Assumes: the caller never pops more than count, and never pushes without
// room for four entries (DEPTH >= LOOK and DEPTH >= LANES).
module iq_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [1:0]           n_pop,
    input  logic                 push,
    input  logic [2:0]           n_in,
    input  logic [LANES*CLS_W-1:0] in_cls,
    input  logic [LANES*DW-1:0]  in_data,
    output iclass_e              head_cls  [LOOK],
    output logic [DW-1:0]        head_data [LOOK],
    output logic [CNT_W-1:0]     count
);

    iclass_e       q_cls    [DEPTH];
    logic [DW-1:0] q_data   [DEPTH];
    iclass_e       nxt_cls  [DEPTH];
    logic [DW-1:0] nxt_data [DEPTH];

    // Next contents: survivors shifted down, then new lanes behind them.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            int k;
            src = i + int'(n_pop);
            k   = i - (int'(count) - int'(n_pop));
            nxt_cls[i]  = q_cls[i];
            nxt_data[i] = q_data[i];
            if (src < int'(count)) begin
                nxt_cls[i]  = q_cls[src];
                nxt_data[i] = q_data[src];
            end else if (push && k >= 0 && k < int'(n_in)) begin
                nxt_cls[i]  = iclass_e'(in_cls[k*CLS_W +: CLS_W]);
                nxt_data[i] = in_data[k*DW +: DW];
            end
        end
    end

    // Occupancy counter: cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            count <= CNT_W'(int'(count) - int'(n_pop) + (push ? int'(n_in) : 0));
        end
    end

    // Class storage: reset to a harmless code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q_cls[i] <= CLS_SIMPLE;
        end else begin
            q_cls <= nxt_cls;
        end
    end

    // Payload storage: qualified by count, so no reset is needed.
    always_ff @(posedge clk) begin
        q_data <= nxt_data;
    end

    for (genvar s = 0; s < LOOK; s++) begin : g_head
        assign head_cls[s]  = q_cls[s];
        assign head_data[s] = q_data[s];
    end

endmodule

// File: rtl/iq_steer.sv
// Module: iq_steer
// Steering logic. It walks the three oldest slots in order and grants each
// one a unit until a slot cannot be placed. Slots 0 and 1 may use any unit;
// slot 2 may only use the branch port.
// Assumes: head_vld is thermometer coded (slot n valid implies slot n-1 valid).
module iq_steer
    import iq_pkg::*;
(
    input  logic             flush,
    input  logic [LOOK-1:0]  head_vld,
    input  iclass_e          head_cls [LOOK],
    input  logic [UNITS-1:0] unit_free,
    output logic [UNITS-1:0] grant    [LOOK],
    output logic [1:0]       n_pop
);

    // Picks the unit for one class out of the still-available set, one-hot.
    function automatic logic [UNITS-1:0] pick(iclass_e c, logic [UNITS-1:0] av);
        logic [UNITS-1:0] g;
        g = '0;
        case (c)
            CLS_SIMPLE: begin
                if (av[U_INT1])      g[U_INT1] = 1'b1;
                else if (av[U_INT2]) g[U_INT2] = 1'b1;
            end
            CLS_CPLX: g[U_INT1] = av[U_INT1];
            CLS_FP:   g[U_FPU]  = av[U_FPU];
            CLS_LS:   g[U_LSU]  = av[U_LSU];
            CLS_BR:   g[U_BR]   = av[U_BR];
            default:  g = '0;
        endcase
        return g;
    endfunction

    logic [UNITS-1:0] av1;
    logic [UNITS-1:0] av2;

    // In-order grant chain across the three oldest slots.
    always_comb begin
        grant[0] = (head_vld[0] && !flush) ? pick(head_cls[0], unit_free) : '0;
        av1      = unit_free & ~grant[0];
        grant[1] = (|grant[0] && head_vld[1]) ? pick(head_cls[1], av1) : '0;
        av2      = av1 & ~grant[1];
        grant[2] = (|grant[1] && head_vld[2] && head_cls[2] == CLS_BR)
                   ? pick(CLS_BR, av2) : '0;
        n_pop    = 2'(|grant[0]) + 2'(|grant[1]) + 2'(|grant[2]);
    end

endmodule

// File: rtl/iq_dual_dispatch.sv
// Module: iq_dual_dispatch (top)
// Instruction queue with two-wide issue to the execution units and one
// extra branch issue per cycle. The fetch side uses valid/ready and always
// reserves room for a full group. Issue outputs are combinational from the
// queue head and the unit free flags.
// Assumes: each unit takes an issued instruction in the cycle it is offered.
module iq_dual_dispatch
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   fetch_valid,
    input  logic [2:0]             fetch_count,
    input  logic [LANES*CLS_W-1:0] fetch_cls,
    input  logic [LANES*DW-1:0]    fetch_data,
    output logic                   fetch_ready,
    input  logic [UNITS-1:0]       unit_free,
    output logic [UNITS-1:0]       issue_valid,
    output logic [UNITS*DW-1:0]    issue_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count;
    iclass_e          head_cls  [LOOK];
    logic [DW-1:0]    head_data [LOOK];
    logic [LOOK-1:0]  head_vld;
    logic [UNITS-1:0] grant     [LOOK];
    logic [1:0]       n_pop;
    logic [2:0]       n_in;
    logic             push;

    // Fetch acceptance: room for four entries and no flush.
    always_comb begin
        fetch_ready = !flush && (int'(count) <= DEPTH - LANES);
        push        = fetch_valid && fetch_ready;
        n_in        = (fetch_count > 3'(LANES)) ? 3'(LANES) : fetch_count;
    end

    for (genvar s = 0; s < LOOK; s++) begin : g_vld
        assign head_vld[s] = int'(count) > s;
    end

    iq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .n_pop     (n_pop),
        .push      (push),
        .n_in      (n_in),
        .in_cls    (fetch_cls),
        .in_data   (fetch_data),
        .head_cls  (head_cls),
        .head_data (head_data),
        .count     (count)
    );

    iq_steer u_steer (
        .flush     (flush),
        .head_vld  (head_vld),
        .head_cls  (head_cls),
        .unit_free (unit_free),
        .grant     (grant),
        .n_pop     (n_pop)
    );

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        assign issue_valid[u] = grant[0][u] | grant[1][u] | grant[2][u];
        assign issue_data[u*DW +: DW] = grant[0][u] ? head_data[0] :
                                        grant[1][u] ? head_data[1] : head_data[2];
    end

endmodule

// File: rtl/iq_dispatch_chk.sv
// Module: iq_dispatch_chk
// Property checker for iq_dual_dispatch, bound into every instance.
// Assumes: count is the occupancy register of the top module.
module iq_dispatch_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             fetch_ready,
    input logic [4:0]       issue_valid,
    input logic [CNT_W-1:0] count
);

    // R3
    exec_pair_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_valid[3:0]) <= 2);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> issue_valid == 5'b0);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);

    // R2
    ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> int'(count) <= DEPTH - 4);

    // R9
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R4
    issue_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_valid) <= int'(count));

endmodule

bind iq_dual_dispatch iq_dispatch_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_ready (fetch_ready),
    .issue_valid (issue_valid),
    .count       (count)
);

// File: tb/iq_dual_dispatch_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, compared
// cycle by cycle against a queue model written from the requirements.
module iq_dual_dispatch_test;

    localparam int DEPTH = 8;
    localparam int DW    = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [2:0]      fetch_count = '0;
    logic [11:0]     fetch_cls = '0;
    logic [4*DW-1:0] fetch_data = '0;
    logic            fetch_ready;
    logic [4:0]      unit_free = '0;
    logic [4:0]      issue_valid;
    logic [5*DW-1:0] issue_data;

    iq_dual_dispatch #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_count(fetch_count),
        .fetch_cls(fetch_cls), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
        .unit_free(unit_free), .issue_valid(issue_valid), .issue_data(issue_data)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0]    m_cls [16];
    logic [DW-1:0] m_dat [16];
    int            m_cnt = 0;
    logic [4:0]    obs_v;
    logic          obs_r;
    int            data_seq = 1;

    // Compares one value and reports a mismatch.
    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Packs four lane class codes, lane 0 in the low bits.
    function automatic logic [11:0] cls4(int c0, int c1, int c2, int c3);
        return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
    endfunction

    // Fresh, distinct payloads for one fetch group.
    function automatic logic [4*DW-1:0] dat4();
        logic [4*DW-1:0] d;
        for (int k = 0; k < 4; k++) d[k*DW +: DW] = DW'(32'hA000_0000 + data_seq + k);
        data_seq += 4;
        return d;
    endfunction

    // Random class mix weighted toward integer work.
    function automatic int rnd_cls();
        int r;
        r = int'($urandom % 10);
        if (r < 4) return 0;
        if (r == 4) return 1;
        if (r == 5) return 2;
        if (r < 8) return 3;
        return 4;
    endfunction

    // Drives one cycle, checks outputs against the model, then advances the model.
    task automatic step(string tag, logic fl, logic fv, logic [2:0] fc,
                        logic [11:0] fcl, logic [4*DW-1:0] fd, logic [4:0] fr);
        logic [4:0]    av;
        logic [4:0]    ev;
        logic [DW-1:0] ed [5];
        logic          erdy;
        int            pops;
        int            n;
        @(negedge clk);
        flush = fl; fetch_valid = fv; fetch_count = fc;
        fetch_cls = fcl; fetch_data = fd; unit_free = fr;
        #1;
        av = fr; ev = '0; pops = 0;
        for (int u = 0; u < 5; u++) ed[u] = '0;
        if (!fl) begin
            for (int s = 0; s < 3; s++) begin
                int u;
                u = -1;
                if (s >= m_cnt) break;
                if (s == 2 && m_cls[2] != 3'd4) break;   // R7 only branches from slot 2
                case (m_cls[s])
                    3'd0: u = av[0] ? 0 : (av[1] ? 1 : -1);   // R5
                    3'd1: u = av[0] ? 0 : -1;
                    3'd2: u = av[2] ? 2 : -1;                 // R6
                    3'd3: u = av[3] ? 3 : -1;
                    3'd4: u = av[4] ? 4 : -1;
                    default: u = -1;
                endcase
                if (u < 0) break;                             // R4 in order
                ev[u] = 1'b1; ed[u] = m_dat[s]; av[u] = 1'b0; pops++;
            end
        end
        erdy = !fl && (m_cnt <= DEPTH - 4);
        obs_v = issue_valid;
        obs_r = fetch_ready;
        check(tag, "issue_valid", longint'(issue_valid), longint'(ev));
        for (int u = 0; u < 5; u++)
            if (ev[u]) check("R9", $sformatf("issue_data lane %0d", u),
                             longint'(issue_data[u*DW +: DW]), longint'(ed[u]));
        check("R2", "fetch_ready", longint'(fetch_ready), longint'(erdy));
        if (fl) begin
            m_cnt = 0;
        end else begin
            for (int i = 0; i < m_cnt - pops; i++) begin
                m_cls[i] = m_cls[i + pops];
                m_dat[i] = m_dat[i + pops];
            end
            m_cnt -= pops;
            if (fv && erdy) begin
                n = (fc > 3'd4) ? 4 : int'(fc);
                for (int k = 0; k < n; k++) begin
                    m_cls[m_cnt + k] = fcl[k*3 +: 3];
                    m_dat[m_cnt + k] = fd[k*DW +: DW];
                end
                m_cnt += n;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4211));
        repeat (3) @(negedge clk);
        #1;
        check("R1", "issue_valid in reset", longint'(issue_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 empty after reset
        check("R1", "issue_valid after reset", longint'(issue_valid), 0);
        check("R1", "fetch_ready after reset", longint'(fetch_ready), 1);

        // R7: full three-wide issue, built while every unit is busy
        step("R6", 0, 1, 3'd4, cls4(0, 0, 4, 2), dat4(), 5'b00000);
        step("R7", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R7", "three-wide issue", longint'(obs_v), 5'b10011);
        step("R6", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R6", "fp alone", longint'(obs_v), 5'b00100);

        // R5: complex then simple splits across both integer units
        step("R5", 0, 1, 3'd2, cls4(1, 0, 0, 0), dat4(), 5'b00000);
        step("R5", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R5", "complex to int1, simple to int2", longint'(obs_v), 5'b00011);

        // R5: only integer unit 2 free takes the older simple
        step("R5", 0, 1, 3'd2, cls4(0, 0, 0, 0), dat4(), 5'b00000);
        step("R5", 0, 0, 3'd0, '0, '0, 5'b00010);
        check("R5", "simple to int2 when int1 busy", longint'(obs_v), 5'b00010);
        step("R5", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R5", "remaining simple to int1", longint'(obs_v), 5'b00001);

        // R3: two fp in a row, only one to the single fp unit
        step("R3", 0, 1, 3'd2, cls4(2, 2, 0, 0), dat4(), 5'b00000);
        step("R3", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R3", "one per unit", longint'(obs_v), 5'b00100);
        // R4: blocked fp holds back the load/store behind it
        step("R4", 0, 1, 3'd1, cls4(3, 0, 0, 0), dat4(), 5'b11011);
        check("R4", "blocked head stalls younger", longint'(obs_v), 5'b00000);
        step("R4", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R4", "head and younger issue together", longint'(obs_v), 5'b01100);

        // R2: fill to capacity, ready drops
        step("R2", 0, 1, 3'd4, cls4(3, 3, 3, 3), dat4(), 5'b00000);
        step("R2", 0, 1, 3'd4, cls4(2, 1, 0, 4), dat4(), 5'b00000);
        step("R2", 0, 1, 3'd4, cls4(0, 0, 0, 0), dat4(), 5'b00000);
        check("R2", "ready low when full", longint'(obs_r), 0);

        // R8: flush with a full queue and a fetch offered
        step("R8", 1, 1, 3'd4, cls4(0, 0, 0, 0), dat4(), 5'b11111);
        check("R8", "no issue during flush", longint'(obs_v), 0);
        step("R8", 0, 0, 3'd0, '0, '0, 5'b11111);
        check("R8", "empty after flush", longint'(obs_v), 0);
        check("R8", "ready after flush", longint'(obs_r), 1);

        // R9: random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            logic [4:0] fr;
            for (int u = 0; u < 5; u++) fr[u] = ($urandom % 10) < 7;
            step("R4", ($urandom % 40) == 0, ($urandom % 10) < 6, 3'($urandom % 5),
                 cls4(rnd_cls(), rnd_cls(), rnd_cls(), rnd_cls()), dat4(), fr);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule